// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a register-mapped general-purpose pin controller for up to 32 pins. Each pin can be an input or an output. Output pins drive a level taken from a value register, and reading that register returns the synchronized level of input pins and the driven level of output pins. A processor reaches all of this through a plain word-wide register port: one write strobe, a word index, write data and read data that is registered one cycle after the index.

Every pin can also raise an interrupt. Three per-pin configuration planes choose the trigger: an edge/level plane, a polarity plane and a dual-edge plane. Detected triggers collect in a raw status register regardless of enables. Edge detections hold until software writes a one to the matching bit of a clear register. Level detections follow the pin every cycle. Pending is status masked by the enable plane, and one registered interrupt line is raised while any pin is pending. A read-only version word reports whether the dual-edge plane is built in.

The input pins pass through a two-stage synchronizer before edge and level detection. Pad buffers are outside the block, which presents separate output-value and output-enable vectors.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every configuration register (value, direction, enable, edge, polarity, dual-edge) reads 0, version reads 3, `irq` is low, `pin_out` is 0 and every pin is an output (`pin_oe` all ones).
- R2: A direction bit of 1 makes the pin an input (`pin_oe` bit 0), and a bit of 0 makes it an output (`pin_oe` bit 1). `pin_out` equals the value register one cycle after it is written.
- R3: Reading the value register (word 0) returns the synchronized input level for input pins and the value-register bit for output pins.
- R4: Level trigger (edge bit 0): the status bit is 1 while the synchronized pin is at its active level. Polarity 1 means high is active and polarity 0 means low is active. Writing a clear bit while the level is still active has no lasting effect.
- R5: Edge trigger (edge bit 1, dual-edge bit 0): polarity 1 detects rising edges and polarity 0 detects falling edges. A detection holds until it is cleared.
- R6: With the dual-edge bit and the edge bit both 1, both edges are detected and polarity is ignored. With the dual-edge bit 1 and the edge bit 0, the pin behaves as an ordinary level trigger.
- R7: Writing a 1 to a bit of the clear register (word 5) clears that held edge detection. Writing 0 leaves it unchanged.
- R8: Pending (word 4) reads status AND enable. Status (word 3) does not depend on the enable register (word 2).
- R9: `irq` is high exactly one cycle after any pin is both pending and enabled, and low one cycle after none is.
- R10: Version (word 8) reads the constant 3 when the dual-edge plane is built in, and 2 when it is not. Writes to the version, status and pending words are ignored.
- R11: Word indices are: value 0, direction 1, enable 2, status 3, pending 4, clear 5, edge 6, polarity 7, version 8, dual-edge 9. `reg_rdata` holds the addressed word one cycle after `reg_word` is presented, and bits at or above `NPINS` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_word | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin input levels |
| pin_out | output | NPINS | Driven output levels |
| pin_oe | output | NPINS | Output enables, 1 = pin driven |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that `reg_word` and `reg_wr` are stable and known at each rising edge, and that an asynchronous `pin_in` may change at any time because only synchronized copies reach the trigger logic. The bench drives the register port and the pins on falling edges only. After changing pins it waits several cycles so that the synchronizer and edge stage have settled before it reads status. It clears stale edge detections before each transition, so every expected status word depends only on the mode and the pin pattern before and after the transition.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [WORD_W-1:0] W_VALUE = 4'd0;
  localparam logic [WORD_W-1:0] W_DIR   = 4'd1;
  localparam logic [WORD_W-1:0] W_IEN   = 4'd2;
  localparam logic [WORD_W-1:0] W_STAT  = 4'd3;
  localparam logic [WORD_W-1:0] W_PEND  = 4'd4;
  localparam logic [WORD_W-1:0] W_CLR   = 4'd5;
  localparam logic [WORD_W-1:0] W_EDGE  = 4'd6;
  localparam logic [WORD_W-1:0] W_POL   = 4'd7;
  localparam logic [WORD_W-1:0] W_VER   = 4'd8;
  localparam logic [WORD_W-1:0] W_DUAL  = 4'd9;

  function automatic logic [DATA_W-1:0] version_word(input bit has_dual);
    return has_dual ? DATA_W'(3) : DATA_W'(2);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic edge_sel,
  input  logic pol,
  input  logic dual,
  input  logic clr,
  output logic stat
);
  logic prev_q, stat_q;
  logic rise, fall, evt, lvl_hit;

  always_comb begin
    rise    = level & ~prev_q;
    fall    = ~level & prev_q;
    evt     = dual ? (rise | fall) : (pol ? rise : fall);
    lvl_hit = pol ? level : ~level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (edge_sel) stat_q <= (stat_q & ~clr) | evt;
      else          stat_q <= lvl_hit;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS    = 32,
  parameter bit          HAS_DUAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  pin_sync,
  input  logic [NPINS-1:0]  stat,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  outv,
  output logic [NPINS-1:0]  ien,
  output logic [NPINS-1:0]  edge_sel,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  dual,
  output logic [NPINS-1:0]  clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] VERSION = version_word(HAS_DUAL);

  logic [NPINS-1:0]  dir_q, out_q, ien_q, edge_q, pol_q;
  logic [NPINS-1:0]  pin_view, pend;
  logic [DATA_W-1:0] rd_next, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      case (word)
        W_VALUE: out_q  <= wdata[NPINS-1:0];
        W_DIR:   dir_q  <= wdata[NPINS-1:0];
        W_IEN:   ien_q  <= wdata[NPINS-1:0];
        W_EDGE:  edge_q <= wdata[NPINS-1:0];
        W_POL:   pol_q  <= wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (HAS_DUAL) begin : g_dual
      logic [NPINS-1:0] dual_q;
      always_ff @(posedge clk) begin
        if (rst)                       dual_q <= '0;
        else if (wr && word == W_DUAL) dual_q <= wdata[NPINS-1:0];
      end
      assign dual = dual_q;
    end else begin : g_nodual
      assign dual = '0;
    end
  endgenerate

  assign clr = (wr && word == W_CLR) ? wdata[NPINS-1:0] : '0;

  always_comb begin
    pin_view = (pin_sync & dir_q) | (out_q & ~dir_q);
    pend     = stat & ien_q;
    rd_next  = '0;
    case (word)
      W_VALUE: rd_next[NPINS-1:0] = pin_view;
      W_DIR:   rd_next[NPINS-1:0] = dir_q;
      W_IEN:   rd_next[NPINS-1:0] = ien_q;
      W_STAT:  rd_next[NPINS-1:0] = stat;
      W_PEND:  rd_next[NPINS-1:0] = pend;
      W_EDGE:  rd_next[NPINS-1:0] = edge_q;
      W_POL:   rd_next[NPINS-1:0] = pol_q;
      W_VER:   rd_next             = VERSION;
      W_DUAL:  rd_next[NPINS-1:0] = dual;
      default: rd_next             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign dir      = dir_q;
  assign outv     = out_q;
  assign ien      = ien_q;
  assign edge_sel = edge_q;
  assign pol      = pol_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS    = 32,
  parameter bit          HAS_DUAL = 1'b1,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_word,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] pin_sync, stat_q;
  logic [NPINS-1:0] dir_q, out_q, ien_q, edge_q, pol_q, dual_q, clr_p;
  logic             irq_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_in),
    .dout(pin_sync)
  );

  gpio_regfile #(.NPINS(NPINS), .HAS_DUAL(HAS_DUAL)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .word    (reg_word),
    .wdata   (reg_wdata),
    .pin_sync(pin_sync),
    .stat    (stat_q),
    .dir     (dir_q),
    .outv    (out_q),
    .ien     (ien_q),
    .edge_sel(edge_q),
    .pol     (pol_q),
    .dual    (dual_q),
    .clr     (clr_p),
    .rdata   (reg_rdata)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      gpio_trig_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .level   (pin_sync[p]),
        .edge_sel(edge_q[p]),
        .pol     (pol_q[p]),
        .dual    (dual_q[p]),
        .clr     (clr_p[p]),
        .stat    (stat_q[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & ien_q);
  end

  assign irq     = irq_q;
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS    = 32,
  parameter bit          HAS_DUAL = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [WORD_W-1:0] reg_word,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  stat,
  input logic [NPINS-1:0]  ien
);
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & ien)) |=> irq);

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & ien)) |=> !irq);

  // R10
  version_const_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_word == W_VER) |=> (reg_rdata == version_word(HAS_DUAL)));

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_word == W_DIR) |=> (pin_oe == ~$past(reg_wdata[NPINS-1:0])));

  // R2
  value_to_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_word == W_VALUE) |=> (pin_out == $past(reg_wdata[NPINS-1:0])));

  // R8
  pending_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_word == W_PEND) |=> (reg_rdata[NPINS-1:0] == $past(stat & ien)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .HAS_DUAL(HAS_DUAL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_word (reg_word),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq      (irq),
  .stat     (stat_q),
  .ien      (ien_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_word = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .HAS_DUAL(1'b1)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_word = w;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // mode: 0 level-high, 1 level-low, 2 rising, 3 falling,
  //       4 dual pol0, 5 dual pol1, 6 dual bit with edge bit 0 (level-high)
  function automatic logic [NP-1:0] expect_stat(input int mode, input logic [NP-1:0] s,
                                                 input logic [NP-1:0] e);
    case (mode)
      0: return e;
      1: return ~e;
      2: return e & ~s;
      3: return s & ~e;
      4, 5: return s ^ e;
      default: return e;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] sv [4];
    logic [NP-1:0] ev [4];
    sv[0] = 8'h00; ev[0] = 8'hFF;
    sv[1] = 8'hFF; ev[1] = 8'h00;
    sv[2] = 8'h5A; ev[2] = 8'h3C;
    sv[3] = 8'hC3; ev[3] = 8'h96;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe", {24'd0, pin_oe}, 32'hFF);
    chk("R1 pin_out", {24'd0, pin_out}, 32'h0);
    for (int w = 0; w < 10; w++) begin
      if (w == 0 || w == 1 || w == 2 || w == 6 || w == 7 || w == 9) begin
        rd(w[3:0], d);
        chk($sformatf("R1 word %0d", w), d, 32'h0);
      end
    end
    rd(4'd8, d); chk("R1 R10 version", d, 32'd3);

    // R2 R3 direction and value
    wr(4'd0, 32'hA5);
    chk("R2 pin_out", {24'd0, pin_out}, 32'hA5);
    rd(4'd0, d); chk("R3 all outputs", d, 32'hA5);
    wr(4'd1, 32'hF0);
    chk("R2 pin_oe", {24'd0, pin_oe}, 32'h0F);
    pin_in = 8'h3C;
    settle();
    rd(4'd0, d); chk("R3 mixed", d, 32'h35);
    wr(4'd1, 32'hFF);

    // R4 R5 R6 sweep over trigger modes and pin transitions
    for (int m = 0; m < 7; m++) begin
      wr(4'd6, (m >= 2 && m <= 5) ? 32'hFF : 32'h0);
      wr(4'd7, (m == 0 || m == 2 || m == 5 || m == 6) ? 32'hFF : 32'h0);
      wr(4'd9, (m >= 4) ? 32'hFF : 32'h0);
      for (int p = 0; p < 4; p++) begin
        pin_in = sv[p];
        settle();
        wr(4'd5, 32'hFF);
        settle();
        pin_in = ev[p];
        settle();
        rd(4'd3, d);
        chk($sformatf("R4 R5 R6 mode %0d pattern %0d", m, p), d,
            {24'd0, expect_stat(m, sv[p], ev[p])});
      end
    end

    // R5 R7 hold and clear of edge detections
    wr(4'd9, 32'h0); wr(4'd6, 32'hFF); wr(4'd7, 32'hFF);
    pin_in = 8'h00; settle();
    wr(4'd5, 32'hFF);
    pin_in = 8'h03; settle();
    pin_in = 8'h00; settle();
    rd(4'd3, d); chk("R5 held after pulse", d, 32'h03);
    wr(4'd5, 32'h00);
    rd(4'd3, d); chk("R7 zero clear no effect", d, 32'h03);
    wr(4'd5, 32'h01);
    rd(4'd3, d); chk("R7 one clears bit", d, 32'h02);

    // R4 clear while level active
    wr(4'd6, 32'h0); wr(4'd7, 32'hFF);
    pin_in = 8'h0F; settle();
    wr(4'd5, 32'hFF);
    settle();
    rd(4'd3, d); chk("R4 level re-set", d, 32'h0F);

    // R8 R9 pending and irq
    wr(4'd2, 32'h30); settle();
    rd(4'd4, d); chk("R8 pending none", d, 32'h0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);
    rd(4'd3, d); chk("R8 status ignores enable", d, 32'h0F);
    wr(4'd2, 32'h18); settle();
    rd(4'd4, d); chk("R8 pending one", d, 32'h08);
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    pin_in = 8'h07; settle();
    chk("R9 irq drops", {31'd0, irq}, 32'd0);

    // R10 read-only words
    wr(4'd8, 32'h0); wr(4'd3, 32'hFF); wr(4'd4, 32'hFF);
    rd(4'd8, d); chk("R10 version kept", d, 32'd3);
    rd(4'd3, d); chk("R10 status kept", d, 32'h07);

    // R11 upper bits read zero
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, d); chk("R11 upper bits zero", d, 32'hFF);

    done = 1'b1;
    report();
  end
endmodule